// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Register Pair

This block keeps a 64-bit signed accumulator as two 32-bit words, a high word and a low word. Each start strobe adds one signed product to the accumulator. The operation select chooses between two products. The long product uses the full 32-bit operands. The word product uses only the low 16 bits of each operand, taken as signed. A clear command empties the accumulator. A done strobe marks the cycle in which the new accumulator value can first be read.

A saturation-mode input changes how the sum is written back, and each operation has its own rule. In long mode with saturation on, the high word is forced, so the result keeps a 48-bit signed range. In word mode with saturation on, the sum is limited to the signed 32-bit range. When a word sum goes past that range, the low word takes the limit value and the high word is set to 1 as a marker. With saturation off, the 64-bit sum wraps and is written back in full.

Top module: `sat_mac_pair`

## Requirements
- R1: After reset, both accumulator words are zero and `done` is low.
- R2: With `op_sel` = 0 (long), a start adds the signed product of the full 32-bit operands to the 64-bit value {acc_hi, acc_lo}.
- R3: With `op_sel` = 1 (word), a start adds the signed product of operand bits [15:0] only. Operand bits [31:16] have no effect on the result.
- R4: With `sat_en` low, both operations write back the full 64-bit sum, wrapping modulo 2^64.
- R5: In long mode with `sat_en` high, a negative 64-bit sum is written back with its high word ORed with 0xFFFF0000. The low word is unchanged.
- R6: In long mode with `sat_en` high, a sum of zero or more is written back with its high word ANDed with 0x00007FFF. The low word is unchanged.
- R7: In word mode with `sat_en` high, a sum greater than 0x7FFFFFFF writes acc_hi = 1 and acc_lo = 0x7FFFFFFF.
- R8: In word mode with `sat_en` high, a sum less than -2^31 writes acc_hi = 1 and acc_lo = 0x80000000. A sum inside the range is written back unchanged.
- R9: `clear` zeroes both words at the next edge. It wins over a start in the same cycle, and that start then raises no `done`.
- R10: `done` is high for exactly the one cycle after an accepted start. The new accumulator value appears in that same cycle. Without start or clear, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 1 | 0 = long (32x32) product, 1 = word (16x16) product |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| start | input | 1 | Accumulate strobe |
| sat_en | input | 1 | Saturating write-back enable |
| clear | input | 1 | Zero the accumulator; has priority over start |
| acc_hi | output | 32 | High accumulator word |
| acc_lo | output | 32 | Low accumulator word |
| done | output | 1 | One-cycle strobe marking the updated accumulator |

## Verification
The hardest states to reach are the word-mode saturation edges. A single 16x16 product can reach at most 2^30, so no one start can leave the 32-bit range. The stimulus therefore chains several word accumulations of the extreme operands 0x8000 and 0x7FFF. This walks the sum to just inside -2^31, then past it, and in a separate run past +2^31-1. The long-mode 2^63 wrap and the case where the marker high word of 1 is fed back into a later unsaturated sum are reached in the same chained way.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    OP_LONG = 1'b0,
    OP_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int W = 32
) (
  input  mac_pkg::mac_op_e op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [2*W-1:0]   prod
);
  localparam int HALF = W / 2;
  localparam int DW   = 2 * W;

  function automatic logic [DW-1:0] long_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [DW-1:0] ex, ey;
    ex = {{W{x[W-1]}}, x};
    ey = {{W{y[W-1]}}, y};
    return ex * ey;
  endfunction

  function automatic logic [DW-1:0] word_mul(input logic [HALF-1:0] x, input logic [HALF-1:0] y);
    logic [DW-1:0] ex, ey;
    ex = {{(DW-HALF){x[HALF-1]}}, x};
    ey = {{(DW-HALF){y[HALF-1]}}, y};
    return ex * ey;
  endfunction

  always_comb begin
    if (op == mac_pkg::OP_WORD) prod = word_mul(a[HALF-1:0], b[HALF-1:0]);
    else                        prod = long_mul(a, b);
  end
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
  parameter int W = 32
) (
  input  mac_pkg::mac_op_e op,
  input  logic             sat_en,
  input  logic [2*W-1:0]   sum,
  output logic [W-1:0]     res_hi,
  output logic [W-1:0]     res_lo,
  output logic             word_over,
  output logic             word_under
);
  localparam int HALF = W / 2;
  localparam int DW   = 2 * W;
  localparam logic [W-1:0]  HI_NEG_SET  = {{HALF{1'b1}}, {(W-HALF){1'b0}}};
  localparam logic [W-1:0]  HI_POS_KEEP = {{(W-HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [DW-1:0] WORD_MAX    = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [DW-1:0] WORD_MIN    = {{(W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic [W-1:0]  LO_MAX      = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  LO_MIN      = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]  HI_MARK     = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] long_hi_force(input logic [W-1:0] hi, input logic neg);
    return neg ? (hi | HI_NEG_SET) : (hi & HI_POS_KEEP);
  endfunction

  assign word_over  = $signed(sum) > $signed(WORD_MAX);
  assign word_under = $signed(sum) < $signed(WORD_MIN);

  always_comb begin
    res_hi = sum[DW-1:W];
    res_lo = sum[W-1:0];
    if (sat_en) begin
      if (op == mac_pkg::OP_LONG) begin
        res_hi = long_hi_force(sum[DW-1:W], sum[DW-1]);
      end else if (word_over) begin
        res_hi = HI_MARK;
        res_lo = LO_MAX;
      end else if (word_under) begin
        res_hi = HI_MARK;
        res_lo = LO_MIN;
      end
    end
  end
endmodule

// File: rtl/mac_accum_reg.sv
module mac_accum_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] nxt_hi,
  input  logic [W-1:0] nxt_lo,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi   <= '0;
      lo   <= '0;
      done <= 1'b0;
    end else if (clear) begin
      hi   <= '0;
      lo   <= '0;
      done <= 1'b0;
    end else begin
      done <= load;
      if (load) begin
        hi <= nxt_hi;
        lo <= nxt_lo;
      end
    end
  end
endmodule

// File: rtl/sat_mac_pair.sv
module sat_mac_pair #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         start,
  input  logic         sat_en,
  input  logic         clear,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] acc_lo,
  output logic         done
);
  localparam int DW = 2 * W;

  mac_pkg::mac_op_e op;
  logic [DW-1:0]    prod;
  logic [DW-1:0]    sum;
  logic [W-1:0]     nxt_hi, nxt_lo;
  logic             upd_fire;
  logic             word_over, word_under;

  assign op       = mac_pkg::mac_op_e'(op_sel);
  assign upd_fire = start && !clear;
  assign sum      = {acc_hi, acc_lo} + prod;

  mac_product #(.W(W)) u_prod (
    .op   (op),
    .a    (opa),
    .b    (opb),
    .prod (prod)
  );

  mac_saturate #(.W(W)) u_sat (
    .op         (op),
    .sat_en     (sat_en),
    .sum        (sum),
    .res_hi     (nxt_hi),
    .res_lo     (nxt_lo),
    .word_over  (word_over),
    .word_under (word_under)
  );

  mac_accum_reg #(.W(W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .load   (upd_fire),
    .nxt_hi (nxt_hi),
    .nxt_lo (nxt_lo),
    .hi     (acc_hi),
    .lo     (acc_lo),
    .done   (done)
  );
endmodule

// File: rtl/sat_mac_pair_chk.sv
module sat_mac_pair_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_sel,
  input logic         start,
  input logic         sat_en,
  input logic         clear,
  input logic         upd_fire,
  input logic         word_over,
  input logic         word_under,
  input logic [W-1:0] acc_hi,
  input logic [W-1:0] acc_lo,
  input logic         done
);
  localparam int HALF = W / 2;
  localparam logic [W-1:0] LO_MAX  = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] LO_MIN  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] HI_MARK = {{(W-1){1'b0}}, 1'b1};

  AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> done); // R10
  AST_NO_DONE_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> !done); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !clear) |=> ($stable(acc_hi) && $stable(acc_lo))); // R10
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_hi == '0 && acc_lo == '0 && !done)); // R9
  AST_LONG_SAT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && sat_en && !op_sel) |=>
      (acc_hi[W-1:HALF-1] == '0 || acc_hi[W-1:HALF] == '1)); // R5 R6
  AST_WORD_SAT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && sat_en && op_sel) |=>
      (acc_hi == {W{acc_lo[W-1]}} ||
       (acc_hi == HI_MARK && (acc_lo == LO_MAX || acc_lo == LO_MIN)))); // R8
  AST_WORD_OVER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && sat_en && op_sel && word_over) |=>
      (acc_hi == HI_MARK && acc_lo == LO_MAX)); // R7
  AST_WORD_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && sat_en && op_sel && word_under) |=>
      (acc_hi == HI_MARK && acc_lo == LO_MIN)); // R8
endmodule

bind sat_mac_pair sat_mac_pair_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_sel     (op_sel),
  .start      (start),
  .sat_en     (sat_en),
  .clear      (clear),
  .upd_fire   (upd_fire),
  .word_over  (word_over),
  .word_under (word_under),
  .acc_hi     (acc_hi),
  .acc_lo     (acc_lo),
  .done       (done)
);

// File: tb/sat_mac_pair_tb.sv
`timescale 1ns/1ps
module sat_mac_pair_tb;
  localparam int NV = 15;

  typedef struct packed {
    logic        clr;
    logic        op;
    logic        sat;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] hi;
    logic [31:0] lo;
  } vec_t;

  // op 0 = long, 1 = word; clr = clear before the row; expected values chained
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 32'h00000003, 32'h00000005, 32'h00000000, 32'h0000000F}, // R2
    '{1'b0, 1'b0, 1'b0, 32'hFFFFFFFE, 32'h0000000A, 32'hFFFFFFFF, 32'hFFFFFFFB}, // R2
    '{1'b0, 1'b1, 1'b0, 32'h12340004, 32'hABCDFFFD, 32'hFFFFFFFF, 32'hFFFFFFEF}, // R3
    '{1'b1, 1'b0, 1'b0, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000}, // R2
    '{1'b0, 1'b0, 1'b0, 32'h80000000, 32'h80000000, 32'h80000000, 32'h00000000}, // R4
    '{1'b1, 1'b0, 1'b1, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h00007FFF, 32'h00000001}, // R6
    '{1'b1, 1'b0, 1'b1, 32'h80000000, 32'h7FFFFFFF, 32'hFFFF0000, 32'h80000000}, // R5
    '{1'b1, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF}, // R5
    '{1'b1, 1'b1, 1'b1, 32'h00008000, 32'h00008000, 32'h00000000, 32'h40000000}, // R8
    '{1'b0, 1'b1, 1'b1, 32'h00008000, 32'h00008000, 32'h00000001, 32'h7FFFFFFF}, // R7
    '{1'b0, 1'b1, 1'b1, 32'h00000000, 32'h00001234, 32'h00000001, 32'h7FFFFFFF}, // R7
    '{1'b1, 1'b1, 1'b1, 32'hFFFF8000, 32'h00007FFF, 32'hFFFFFFFF, 32'hC0008000}, // R8
    '{1'b0, 1'b1, 1'b1, 32'h00008000, 32'h55557FFF, 32'hFFFFFFFF, 32'h80010000}, // R8
    '{1'b0, 1'b1, 1'b1, 32'h00008000, 32'h00007FFF, 32'h00000001, 32'h80000000}, // R8
    '{1'b0, 1'b1, 1'b0, 32'h00008000, 32'h00007FFF, 32'h00000001, 32'h40008000}  // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_sel = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        start = 1'b0, sat_en = 1'b0, clear = 1'b0;
  logic [31:0] acc_hi, acc_lo;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sat_mac_pair u_dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opa(opa), .opb(opb),
    .start(start), .sat_en(sat_en), .clear(clear),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic accumulate(input logic op, input logic sat, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_sel = op; sat_en = sat; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(acc_hi == 0 && acc_lo == 0 && !done, "R1 reset state", {acc_hi, acc_lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(acc_hi == 0 && acc_lo == 0 && !done, "R1 after release", {acc_hi, acc_lo}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].clr) pulse_clear();
      accumulate(VECS[i].op, VECS[i].sat, VECS[i].a, VECS[i].b);
      check({acc_hi, acc_lo} == {VECS[i].hi, VECS[i].lo},
            $sformatf("R2/R3/R4/R5/R6/R7/R8 vector %0d", i),
            {acc_hi, acc_lo}, {VECS[i].hi, VECS[i].lo});
      check(done == 1'b1, $sformatf("R10 done with vector %0d", i), {63'd0, done}, 64'd1);
    end

    // R10: done drops after one cycle; idle operand changes leave the value alone
    @(negedge clk);
    opa = 32'h7FFFFFFF; opb = 32'h7FFFFFFF; op_sel = 1'b0; sat_en = 1'b0;
    check(done == 1'b0, "R10 done single pulse", {63'd0, done}, 64'd0);
    repeat (3) @(negedge clk);
    check({acc_hi, acc_lo} == 64'h00000001_40008000, "R10 idle hold",
          {acc_hi, acc_lo}, 64'h00000001_40008000);

    // R3: only low halves count in word mode
    pulse_clear();
    accumulate(1'b1, 1'b0, 32'hFFFF0002, 32'h7FFF0003);
    check({acc_hi, acc_lo} == 64'd6, "R3 upper operand bits ignored", {acc_hi, acc_lo}, 64'd6);

    // R9: clear beats a simultaneous start, no done
    accumulate(1'b0, 1'b0, 32'd100, 32'd100);
    @(negedge clk);
    op_sel = 1'b0; opa = 32'd9; opb = 32'd9; start = 1'b1; clear = 1'b1;
    @(negedge clk);
    start = 1'b0; clear = 1'b0;
    check({acc_hi, acc_lo} == 64'd0, "R9 clear priority value", {acc_hi, acc_lo}, 64'd0);
    check(done == 1'b0, "R9 no done on cleared start", {63'd0, done}, 64'd0);

    // R4: wrap at 2^64
    pulse_clear();
    accumulate(1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000001);
    accumulate(1'b0, 1'b0, 32'h00000001, 32'h00000001);
    check({acc_hi, acc_lo} == 64'd0, "R4 wrap through zero", {acc_hi, acc_lo}, 64'd0);

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule